// File: doc/BRIEF.md
# Statistical ISI Error-Probability Profile Engine

This block computes, for one sampling phase of a serial receiver, the exact probability mass of the received sample level under random equiprobable data. From that mass it derives the bit-error probability for every slicer threshold. A sampled pulse response is presented as a set of small signed integers. One of them, chosen by an index, is the main cursor. Every other sample is an intersymbol-interference tap that adds either nothing or its own value, each with probability one half.

After a start strobe, the engine builds the ISI distribution. It begins with a single impulse at level zero and convolves in one two-point tap per pass over a 128-bin level array. It then forms the shifted distribution for a transmitted one and integrates both distributions into below-threshold counts. When done is raised, any threshold can be presented on the read port. The port returns, combinationally, the ISI mass at that level and the combined error probability at that threshold. All probabilities are exact integer counts. With the default eight ISI taps, mass is in units of 1/256 and error probability in units of 1/512.

Top module: `isi_ber_eye`

## Requirements
- R1: After reset, busy and done are both 0.
- R2: After done, rd_pdf at level L equals the number of the 2^8 ISI tap outcomes whose total ISI equals L. The ISI taps are all samples except the cursor, taken in ascending index order. Sample t sits at pulse_in[t*6 +: 6], two's complement. Levels and rd_lvl are 7-bit two's complement, -64..63.
- R3: After each tap is added, any level below -64 or above 63 is moved to -64 or 63 respectively, and later taps start from the moved level. The one-level (ISI plus cursor) is limited to the same range.
- R4: After done, rd_ber at threshold T equals the number of outcomes whose one-level is below T, plus the number whose ISI level is at or above T. The sum is in units of 1/512.
- R5: At threshold -64, rd_ber is 256 (probability 0.5). When the ISI is zero and the cursor is positive, rd_ber is 0 for every threshold from 1 up to the cursor value.
- R6: busy rises on the edge that samples start. done rises exactly 1289 edges after that edge, and busy falls on the same edge. busy and done are never both high. done stays high until the next accepted start.
- R7: A start while busy is ignored, and the result reflects the samples and cursor index captured at the accepted start.
- R8: cursor_sel selects which sample is the cursor. A value of 9 or more selects sample 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a computation when idle or done |
| pulse_in | input | 54 | Nine 6-bit signed pulse-response samples |
| cursor_sel | input | 4 | Index of the cursor sample |
| rd_lvl | input | 7 | Signed level / threshold to read |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Results valid |
| rd_pdf | output | 9 | ISI mass at rd_lvl, units of 1/256 |
| rd_ber | output | 10 | Error probability at threshold rd_lvl, units of 1/512 |

## Verification
Only done has a cycle-exact due time: it rises 1289 edges after the edge that samples start. The bench counts edges from that edge and compares the count at the first sample where done is seen, checking busy one edge in. rd_pdf and rd_ber are combinational reads of settled arrays. The bench therefore changes rd_lvl only after done and samples 1 ns later, sweeping all 128 levels against exhaustive enumeration of the 256 tap outcomes. An extra start injected mid-run must leave both the result and the 1289-edge latency unchanged.

// File: rtl/isi_ber_eye.sv
module isi_ber_eye #(
  parameter int NTAPS = 9,
  parameter int SW    = 6,
  parameter int LVLW  = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [NTAPS*SW-1:0]       pulse_in,
  input  logic [$clog2(NTAPS)-1:0]  cursor_sel,
  input  logic [LVLW-1:0]           rd_lvl,
  output logic                      busy,
  output logic                      done,
  output logic [NTAPS-1:0]          rd_pdf,
  output logic [NTAPS:0]            rd_ber
);
  localparam int NISI  = NTAPS - 1;
  localparam int CW    = NISI + 1;
  localparam int BW    = NISI + 2;
  localparam int NBINS = 1 << LVLW;
  localparam int IW    = $clog2(NTAPS);
  localparam int XW    = ((LVLW > SW) ? LVLW : SW) + 2;
  localparam logic [BW-1:0] FULL = BW'(1) << NISI;

  typedef enum logic [2:0] {S_IDLE, S_CONV, S_COPY, S_SHIFT, S_INTEG, S_DONE} st_t;

  st_t st;
  logic signed [SW-1:0] smp [NTAPS];
  logic [IW-1:0]   cur, k;
  logic [LVLW-1:0] j, dst, ridx;
  logic [CW-1:0]   pmf [NBINS];
  logic [CW-1:0]   scr [NBINS];
  logic [CW-1:0]   lo0 [NBINS];
  logic [CW-1:0]   lo1 [NBINS];
  logic [CW-1:0]   run0, run1;
  logic signed [SW-1:0] tv;
  logic signed [XW-1:0] dsum;
  logic go, last_k, last_j;

  assign go     = start && (st == S_IDLE || st == S_DONE);
  assign last_k = (k == IW'(NTAPS - 1));
  assign last_j = (j == LVLW'(NBINS - 1));
  assign busy   = (st != S_IDLE) && (st != S_DONE);
  assign tv     = (st == S_SHIFT) ? smp[cur] : smp[k];
  assign dsum   = $signed({{(XW-LVLW){1'b0}}, j}) + $signed({{(XW-SW){tv[SW-1]}}, tv});

  always_comb begin
    if (dsum < 0)                    dst = '0;
    else if (dsum > XW'(NBINS - 1))  dst = '1;
    else                             dst = dsum[LVLW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      k    <= '0;
      j    <= '0;
      cur  <= '0;
      done <= 1'b0;
      run0 <= '0;
      run1 <= '0;
      for (int t = 0; t < NTAPS; t++) smp[t] <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (go) begin
          st   <= S_CONV;
          k    <= '0;
          j    <= '0;
          done <= 1'b0;
          cur  <= (int'(cursor_sel) < NTAPS) ? cursor_sel : '0;
          for (int t = 0; t < NTAPS; t++) smp[t] <= pulse_in[t*SW +: SW];
        end
        S_CONV: begin
          if (k == cur) begin
            if (last_k) st <= S_SHIFT;
            else        k  <= k + 1'b1;
          end else begin
            j <= j + 1'b1;
            if (last_j) st <= S_COPY;
          end
        end
        S_COPY: begin
          if (last_k) st <= S_SHIFT;
          else begin
            k  <= k + 1'b1;
            st <= S_CONV;
          end
        end
        S_SHIFT: begin
          j <= j + 1'b1;
          if (last_j) begin
            st   <= S_INTEG;
            run0 <= '0;
            run1 <= '0;
          end
        end
        S_INTEG: begin
          j    <= j + 1'b1;
          run0 <= run0 + pmf[j];
          run1 <= run1 + scr[j];
          if (last_j) begin
            st   <= S_DONE;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (go) begin
      for (int b = 0; b < NBINS; b++) begin
        pmf[b] <= (b == NBINS/2) ? CW'(1) : '0;
        scr[b] <= '0;
      end
    end else begin
      case (st)
        S_CONV: if (k != cur) begin
          if (dst == j) scr[j] <= scr[j] + (pmf[j] << 1);
          else begin
            scr[j]   <= scr[j] + pmf[j];
            scr[dst] <= scr[dst] + pmf[j];
          end
        end
        S_COPY: for (int b = 0; b < NBINS; b++) begin
          pmf[b] <= scr[b];
          scr[b] <= '0;
        end
        S_SHIFT: scr[dst] <= scr[dst] + pmf[j];
        S_INTEG: begin
          lo0[j] <= run0;
          lo1[j] <= run1;
        end
        default: ;
      endcase
    end
  end

  assign ridx   = {~rd_lvl[LVLW-1], rd_lvl[LVLW-2:0]};
  assign rd_pdf = pmf[ridx];
  assign rd_ber = {1'b0, lo1[ridx]} + FULL - {1'b0, lo0[ridx]};
endmodule

module isi_ber_eye_chk #(
  parameter int NISI = 8,
  parameter int LVLW = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [LVLW-1:0] rd_lvl,
  input logic [NISI+1:0] rd_ber
);
  localparam logic [LVLW-1:0] LMIN = {1'b1, {(LVLW-1){1'b0}}};

  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n) done && !start |=> done);
  assert_busy_exit_R6: assert property (@(posedge clk) disable iff (!rst_n) busy |=> busy || done);
  assert_busy_rise_R7: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start) && !$past(busy));
  assert_low_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && rd_lvl == LMIN |-> rd_ber == ((NISI+2)'(1) << NISI));
  assert_ber_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rd_ber <= ((NISI+2)'(1) << (NISI + 1)));
endmodule

bind isi_ber_eye isi_ber_eye_chk #(.NISI(NTAPS-1), .LVLW(LVLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .rd_lvl(rd_lvl), .rd_ber(rd_ber)
);

// File: tb/isi_ber_eye_tb.sv
module isi_ber_eye_tb;
  localparam int NT = 9;
  localparam int SW = 6;
  localparam int NB = 128;
  localparam int LAT = (NT - 1) * (NB + 1) + 1 + 2 * NB + 1;

  logic clk = 0, rst_n = 0, start = 0;
  logic [NT*SW-1:0] pulse_in = '0;
  logic [3:0] cursor_sel = '0;
  logic [6:0] rd_lvl = '0;
  logic busy, done;
  logic [8:0] rd_pdf;
  logic [9:0] rd_ber;

  int tests = 0, fails = 0;
  int cyc_all = 0;
  logic signed [SW-1:0] vs [NT];
  int cs;
  int h0 [NB];
  int h1 [NB];

  always #2 clk = ~clk;

  isi_ber_eye u_dut (.clk(clk), .rst_n(rst_n), .start(start), .pulse_in(pulse_in),
    .cursor_sel(cursor_sel), .rd_lvl(rd_lvl), .busy(busy), .done(done),
    .rd_pdf(rd_pdf), .rd_ber(rd_ber));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (lvl %0d)", tag, act, exp, $signed(rd_lvl));
    end
  endtask

  function automatic int clampl(input int x);
    if (x < -64) return -64;
    if (x > 63) return 63;
    return x;
  endfunction

  task automatic run(input string tag, input bit inj);
    int ce, cyc, lvl, bi, e0, e1;
    for (int t = 0; t < NT; t++) pulse_in[t*SW +: SW] = vs[t];
    cursor_sel = 4'(cs);
    ce = (cs < NT) ? cs : 0;
    @(negedge clk); start = 1;
    @(posedge clk); #1; start = 0; cyc = 1;
    chk("R6 busy after start", int'(busy), 1);
    while (!done && cyc < 5000) begin
      if (inj && cyc == 500) begin
        pulse_in = ~pulse_in;
        cursor_sel = 4'd3;
        start = 1;
      end
      @(posedge clk); #1; start = 0; cyc++;
    end
    chk(inj ? "R7 latency with ignored start" : "R6 done latency", cyc, LAT);
    for (int b = 0; b < NB; b++) begin h0[b] = 0; h1[b] = 0; end
    for (int m = 0; m < 256; m++) begin
      lvl = 0; bi = 0;
      for (int t = 0; t < NT; t++) if (t != ce) begin
        if (m[bi]) lvl = clampl(lvl + int'(vs[t]));
        bi++;
      end
      h0[lvl + 64]++;
      h1[clampl(lvl + int'(vs[ce])) + 64]++;
    end
    for (int t = 0; t < NB; t++) begin
      e0 = 0; e1 = 0;
      for (int b = 0; b < NB; b++) begin
        if (b < t) e1 += h1[b];
        else       e0 += h0[b];
      end
      rd_lvl = 7'(t - 64);
      #1;
      chk({tag, " pdf"}, int'(rd_pdf), h0[t]);
      chk({tag, " ber"}, int'(rd_ber), e0 + e1);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc_all++;
      if (cyc_all > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog: actual %0d expected <150000", cyc_all);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    #1;
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 done in reset", int'(done), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);

    // R5 clean eye: zero ISI, cursor 20 at index 2
    foreach (vs[t]) vs[t] = '0;
    vs[2] = 6'sd20; cs = 2;
    run("R5 clean eye", 0);

    // R2 R4 mixed small ISI, cursor 16 at index 1
    vs[0] = 6'sd2;  vs[1] = 6'sd16; vs[2] = -6'sd3; vs[3] = 6'sd4; vs[4] = 6'sd2;
    vs[5] = -6'sd2; vs[6] = 6'sd1;  vs[7] = -6'sd1; vs[8] = 6'sd3; cs = 1;
    run("R2 R4 mixed", 0);

    // R3 intermediate clamping, cursor at index 0
    vs[0] = 6'sd10; vs[1] = 6'sd31; vs[2] = 6'sd31; vs[3] = 6'sd31; vs[4] = -6'sd32;
    vs[5] = 6'sd30; vs[6] = -6'sd30; vs[7] = 6'sd25; vs[8] = -6'sd20; cs = 0;
    run("R3 clamp", 0);

    // R8 cursor at last index, negative cursor
    vs[0] = 6'sd5; vs[1] = -6'sd7; vs[2] = 6'sd3; vs[3] = 6'sd9; vs[4] = -6'sd4;
    vs[5] = 6'sd6; vs[6] = -6'sd2; vs[7] = 6'sd8; vs[8] = -6'sd12; cs = 8;
    run("R8 last cursor", 0);

    // R8 out-of-range index selects sample 0
    cs = 12;
    run("R8 out-of-range cursor", 0);

    // R7 start during busy ignored
    vs[0] = 6'sd2;  vs[1] = 6'sd16; vs[2] = -6'sd3; vs[3] = 6'sd4; vs[4] = 6'sd2;
    vs[5] = -6'sd2; vs[6] = 6'sd1;  vs[7] = -6'sd1; vs[8] = 6'sd3; cs = 1;
    run("R7 ignored start", 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule